// File: doc/BRIEF.md
# Laser Drive Pin Fault Monitor

This block protects a laser drive pin against two faults: a resistive path to ground and a short to the laser supply. An analog comparator outside the block reports whether the drive pin currently reads as grounded. In normal running the block holds its active-low supply enable low, which keeps the laser powered. It latches a ground fault when the synchronized comparator reports ground on two consecutive samples. When a fault latches, the block raises the supply enable to disconnect the laser and raises a drive-current kill.

The block also checks that its own detector works. Every `PERIOD` running cycles it disconnects the supply for one cycle. It then turns on an internal pull-down on the pin for `SETTLE` cycles and samples the comparator once more while the pull-down is still on. If the pin does not read as grounded at that point, the pin must be held up by the supply, and the block latches a supply-short fault. A fault is cleared only by reset. While a fault is latched, a cause output reports which of the two faults occurred.

Top module: `laser_fault_monitor`

## Requirements
- R1: After reset the block is running normally: `supplyEnN`=0, `driveKill`=0, `testSink`=0, `faultLatched`=0, `faultCause`=0. The cause codes are 0 for none, 1 for ground short and 2 for supply short.
- R2: `supplyEnN` is 0 only while the block is running normally. It is 1 during every self-test cycle and for as long as a fault is latched.
- R3: `driveKill` is 1 in exactly the cycles in which `supplyEnN` is 1.
- R4: While the block is running, a ground fault (cause 1) latches when the synchronized comparator value is 1 on `CONFIRM` (default 2) consecutive qualifying cycles. The comparator passes through `SYNC_STAGES` (default 2) flops. A ground pulse of one cycle latches no fault.
- R5: After `PERIOD` running cycles the block spends one cycle with the supply off and `testSink`=0. It then holds `testSink`=1 for `SETTLE`+1 cycles, the last of which is the sample cycle. `testSink` is never 1 while `supplyEnN` is 0.
- R6: Ground readings are ignored during the self-test and during the first `SYNC_STAGES`+1 running cycles after reset or after a self-test. A passing self-test returns the block to normal running.
- R7: If the synchronized comparator value is 0 in the sample cycle, a supply-short fault (cause 2) latches.
- R8: A latched fault and its cause stay unchanged whatever the comparator input does, until reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinGroundRaw | input | 1 | Comparator output, 1 when the drive pin reads as grounded (asynchronous) |
| supplyEnN | output | 1 | Active-low laser supply enable; 1 disconnects the supply |
| driveKill | output | 1 | Turns off the laser drive current source |
| testSink | output | 1 | Turns on the internal pull-down on the drive pin |
| faultLatched | output | 1 | A fault has been latched |
| faultCause | output | 2 | 0 none, 1 ground short, 2 supply short |

## Verification
A healthy pin model grounds the pin only while `testSink` is high. It shows that self-tests pass repeatedly and that the stale ground still in the synchronizer after a test trips nothing. A one-cycle ground pulse and a two-cycle ground pulse tell the glitch filter apart from a real ground short. A pin stuck high during the pull-down shows the supply-short path. Removing the ground after a fault and then resetting shows that the fault is sticky and that reset clears it. A behavioural model checks every output on every cycle.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  typedef enum logic [2:0] {
    IDLE_RUN,
    TEST_DISABLE,
    TEST_SETTLE,
    TEST_SAMPLE,
    FAULT
  } monState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_GROUND = 2'd1,
    CAUSE_SUPPLY = 2'd2
  } faultCause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tickClr;
    logic tickInc;
    logic streakArm;
  } ctrlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic gndSync;
    logic groundHit;
    logic periodDone;
    logic settleDone;
  } dpStatus_t;

endpackage

// File: rtl/lfm_datapath.sv
module lfm_datapath
  import lfm_pkg::*;
#(
  parameter int PERIOD      = 1024,
  parameter int SETTLE      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinGroundRaw,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);

  localparam int TW    = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int SW    = $clog2(CONFIRM + 1);
  localparam int BLANK = SYNC_STAGES + 1;

  // comparator synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= pinGroundRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinGroundRaw};
      end
    end
  endgenerate

  logic gndSync;
  assign gndSync = syncChain[SYNC_STAGES-1];

  // shared interval counter: running period and settle window
  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tick <= '0;
    else if (strobes.tickClr) tick <= '0;
    else if (strobes.tickInc) tick <= tick + 1'b1;
  end

  logic blankDone;
  assign blankDone = (tick >= TW'(BLANK));

  // consecutive ground sample streak
  logic [SW-1:0] streak;
  logic qualify;
  assign qualify = strobes.streakArm && blankDone && gndSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    streak <= '0;
    else if (!qualify)            streak <= '0;
    else if (streak != SW'(CONFIRM)) streak <= streak + 1'b1;
  end

  assign status.gndSync    = gndSync;
  assign status.groundHit  = qualify && (streak >= SW'(CONFIRM - 1));
  assign status.periodDone = (tick == TW'(PERIOD - 1));
  assign status.settleDone = (tick == TW'(SETTLE - 1));

endmodule

// File: rtl/lfm_control.sv
module lfm_control
  import lfm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output monState_t    state,
  output faultCause_t  cause
);

  monState_t   stateNext;
  faultCause_t causeNext;

  always_comb begin
    stateNext         = state;
    causeNext         = cause;
    strobes.tickClr   = 1'b0;
    strobes.tickInc   = 1'b0;
    strobes.streakArm = (state == IDLE_RUN);
    unique case (state)
      IDLE_RUN: begin
        if (status.groundHit) begin
          stateNext = FAULT;
          causeNext = CAUSE_GROUND;
        end else if (status.periodDone) begin
          stateNext       = TEST_DISABLE;
          strobes.tickClr = 1'b1;
        end else begin
          strobes.tickInc = 1'b1;
        end
      end
      TEST_DISABLE: begin
        stateNext       = TEST_SETTLE;
        strobes.tickClr = 1'b1;
      end
      TEST_SETTLE: begin
        if (status.settleDone) begin
          stateNext       = TEST_SAMPLE;
          strobes.tickClr = 1'b1;
        end else begin
          strobes.tickInc = 1'b1;
        end
      end
      TEST_SAMPLE: begin
        if (status.gndSync) begin
          stateNext       = IDLE_RUN;
          strobes.tickClr = 1'b1;
        end else begin
          stateNext = FAULT;
          causeNext = CAUSE_SUPPLY;
        end
      end
      FAULT: begin
        stateNext = FAULT;
      end
      default: begin
        stateNext = FAULT;
        causeNext = CAUSE_SUPPLY;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE_RUN;
      cause <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      cause <= causeNext;
    end
  end

endmodule

// File: rtl/laser_fault_monitor.sv
module laser_fault_monitor
  import lfm_pkg::*;
#(
  parameter int PERIOD      = 1024,
  parameter int SETTLE      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinGroundRaw,
  output logic       supplyEnN,
  output logic       driveKill,
  output logic       testSink,
  output logic       faultLatched,
  output logic [1:0] faultCause
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;
  monState_t    state;
  faultCause_t  cause;

  lfm_datapath #(
    .PERIOD(PERIOD), .SETTLE(SETTLE),
    .SYNC_STAGES(SYNC_STAGES), .CONFIRM(CONFIRM)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinGroundRaw(pinGroundRaw),
    .strobes(strobes), .status(status)
  );

  lfm_control u_ctrl (
    .clk(clk), .rstN(rstN), .status(status),
    .strobes(strobes), .state(state), .cause(cause)
  );

  assign supplyEnN    = (state != IDLE_RUN);
  assign driveKill    = (state != IDLE_RUN);
  assign testSink     = (state == TEST_SETTLE) || (state == TEST_SAMPLE);
  assign faultLatched = (state == FAULT);
  assign faultCause   = cause;

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       supplyEnN,
  input logic       driveKill,
  input logic       testSink,
  input logic       faultLatched,
  input logic [1:0] faultCause
);

  // R8: a latched fault and its cause hold until reset
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |=> faultLatched && $stable(faultCause));

  // R5: the pull-down is only on while the supply is disconnected
  p_sink_supply_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    testSink |-> supplyEnN && driveKill);

  // R5: the pull-down turns on only after a cycle with the supply already off
  p_test_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testSink) |-> $past(supplyEnN) && !$past(testSink));

  // R1: a nonzero cause is reported exactly when a fault is latched
  p_cause_flag_r1: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched == (faultCause != 2'd0));

  // R7: a supply-short fault can only come out of the sample cycle
  p_supply_from_test_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(faultLatched) && faultCause == 2'd2) |-> $past(testSink));

  // R6: a ground fault never comes out of a self-test cycle
  p_ground_from_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(faultLatched) && faultCause == 2'd1) |-> !$past(supplyEnN));

endmodule

bind laser_fault_monitor lfm_checker u_chk (
  .clk(clk), .rstN(rstN), .supplyEnN(supplyEnN), .driveKill(driveKill),
  .testSink(testSink), .faultLatched(faultLatched), .faultCause(faultCause)
);

// File: tb/tb_laser_fault_monitor.sv
`timescale 1ns/1ps
module tb_laser_fault_monitor;

  localparam int PERIOD  = 64;
  localparam int SETTLE  = 8;
  localparam int SYNCN   = 2;
  localparam int CONFIRM = 2;
  localparam int BLANK   = SYNCN + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinGroundRaw = 1'b0;
  logic supplyEnN, driveKill, testSink, faultLatched;
  logic [1:0] faultCause;

  // pin environment knobs
  logic forceGnd = 1'b0;
  logic stuckHigh = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  int sinkRises = 0;
  logic prevSink = 1'b0;

  always #2.5 clk = ~clk;

  laser_fault_monitor #(.PERIOD(PERIOD), .SETTLE(SETTLE),
    .SYNC_STAGES(SYNCN), .CONFIRM(CONFIRM)) dut (
    .clk(clk), .rstN(rstN), .pinGroundRaw(pinGroundRaw),
    .supplyEnN(supplyEnN), .driveKill(driveKill), .testSink(testSink),
    .faultLatched(faultLatched), .faultCause(faultCause));

  // ---------------- behavioural reference ----------------
  // phase: 0 running, 1 supply-off, 2 settle, 3 sample, 4 fault
  int mPhase = 0;
  int mCount = 0;
  int mRun = 0;
  int mCause = 0;
  bit gndQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCount = 0; mRun = 0; mCause = 0;
      gndQ = {};
      for (int i = 0; i < SYNCN; i++) gndQ.push_back(1'b0);
    end else begin
      bit gs;
      gs = gndQ.pop_front();
      gndQ.push_back(pinGroundRaw);
      case (mPhase)
        0: begin
          if (mCount >= BLANK && gs) mRun++; else mRun = 0;
          if (mRun >= CONFIRM) begin mPhase = 4; mCause = 1; end
          else if (mCount == PERIOD - 1) begin mPhase = 1; mCount = 0; end
          else mCount++;
        end
        1: begin mPhase = 2; mCount = 0; end
        2: begin
          if (mCount == SETTLE - 1) begin mPhase = 3; mCount = 0; end
          else mCount++;
        end
        3: begin
          if (gs) begin mPhase = 0; mCount = 0; mRun = 0; end
          else begin mPhase = 4; mCause = 2; end
        end
        default: ;
      endcase
    end
  end

  task automatic check1(input string req, input string what,
                        input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison and pin model, at the falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check1("R2", "supplyEnN", int'(supplyEnN), int'(mPhase != 0));
      check1("R3", "driveKill", int'(driveKill), int'(mPhase != 0));
      check1("R5", "testSink", int'(testSink), int'(mPhase == 2 || mPhase == 3));
      check1("R8", "faultLatched", int'(faultLatched), int'(mPhase == 4));
      check1("R4", "faultCause", int'(faultCause), mCause);
      if (testSink && !prevSink) sinkRises++;
      prevSink = testSink;
    end
    // pin: pulled down by the sink unless held by the supply, or by an external ground
    pinGroundRaw = (testSink && !stuckHigh) || forceGnd;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; forceGnd = 1'b0; stuckHigh = 1'b0;
    cycles(3);
    rstN = 1'b1;
    prevSink = 1'b0;
  endtask

  task automatic waitRunning(input int minCount);
    // wait until the outputs show normal running, then a little longer
    while (supplyEnN) @(negedge clk);
    cycles(minCount);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    doReset();
    // R1 reset state
    check1("R1", "reset supplyEnN", int'(supplyEnN), 0);
    check1("R1", "reset driveKill", int'(driveKill), 0);
    check1("R1", "reset testSink", int'(testSink), 0);
    check1("R1", "reset faultLatched", int'(faultLatched), 0);
    check1("R1", "reset faultCause", int'(faultCause), 0);

    // healthy pin across several self-tests (R5, R6)
    cycles(5 * (PERIOD + SETTLE + 2));
    check1("R6", "healthy no fault", int'(faultLatched), 0);
    check1("R5", "self-tests ran", int'(sinkRises >= 4), 1);

    // single-cycle ground glitch is filtered (R4)
    waitRunning(10);
    forceGnd = 1'b1; cycles(1); forceGnd = 1'b0;
    cycles(8);
    check1("R4", "glitch ignored", int'(faultLatched), 0);

    // two-cycle ground pulse latches a ground fault (R4)
    waitRunning(10);
    forceGnd = 1'b1; cycles(2); forceGnd = 1'b0;
    cycles(6);
    check1("R4", "ground fault latched", int'(faultLatched), 1);
    check1("R4", "ground cause", int'(faultCause), 1);
    check1("R2", "supply off in fault", int'(supplyEnN), 1);

    // sticky through input activity (R8)
    forceGnd = 1'b1; cycles(20); forceGnd = 1'b0; cycles(100);
    check1("R8", "still latched", int'(faultLatched), 1);
    check1("R8", "cause unchanged", int'(faultCause), 1);

    doReset();
    check1("R8", "reset clears fault", int'(faultLatched), 0);
    check1("R8", "reset clears cause", int'(faultCause), 0);

    // pin held at supply: self-test fails (R7)
    stuckHigh = 1'b1;
    cycles(PERIOD + SETTLE + 10);
    check1("R7", "supply fault latched", int'(faultLatched), 1);
    check1("R7", "supply cause", int'(faultCause), 2);
    check1("R3", "drive killed", int'(driveKill), 1);

    doReset();
    cycles(2 * (PERIOD + SETTLE + 2));
    check1("R6", "recovers after reset", int'(faultLatched), 0);
    summary();
  end

endmodule